// File: doc/BRIEF.md
# Indirect-Addressed Board Control Register Bank

This block is a small bank of board control registers reached over an 8-bit asynchronous parallel bus. A host drives the bus by toggling pins from software: one address line, a read strobe and a write strobe (both active low), and a bidirectional byte-wide data bus. Only two locations are visible on the bus. One is a pointer. The other is a window onto whichever internal register the pointer currently selects.

The internal registers cover several board functions. A status register holds latched pushbutton presses, and each button has its own clear location. Two write-only registers drive an LED group and a seven-segment display, both active low. One read/write register drives the two pins of a serial EEPROM by bit-banging, with a drive-enable bit.

The block runs on one system clock. It samples the strobes, the address line, the data bus and the buttons through two-flop synchronizers, and it commits each write when the write strobe rises. Reads are combinational from the current register state. The data bus is driven only while the read strobe is low.

Top module: `board_ctl_bank`

## Requirements
- R1: A write with `bus_a0` = 0 loads the pointer with the low 4 bits of the data byte. A read with `bus_a0` = 0 returns 0xFF, because the pointer is not directly readable.
- R2: With `bus_a0` = 1, a read or write goes to the internal register whose index equals the current pointer value.
- R3: `rd_n` and `wr_n` are active low and never both low. A write takes effect only after `wr_n` returns high. It commits on the third clock edge after the rising strobe is first sampled, and never while `wr_n` is still low.
- R4: Index 0x0 is the button status register, and it is read-only. Bit 0 is up, bit 1 is left, bit 2 is right, bit 3 is down and bit 4 is enter. A bit reads 0 when that button is latched. All bits reset to 1, and bits 7:5 always read 1. A latch sets on a synchronized rising edge of its button input. A button that stays held does not set its latch again after a clear.
- R5: Writing any value to index 0x1, 0x2, 0x3, 0x4 or 0x5 clears the latch of button 0, 1, 2, 3 or 4 respectively. No other latch changes.
- R6: Index 0x7 is the LED register. `led_n` takes data bits 3:0: bit 0 is error, bit 1 is host, bit 2 is peripheral and bit 3 is session active. A 0 turns an LED on. The register resets to 0xF, and reads of index 0x7 return 0xFF.
- R7: Index 0x8 is the display register. `seg_n` takes data bits 7:0: bits 0 to 6 are segments A to G and bit 7 is the decimal point. A 0 lights a segment. The register resets to 0xFF, and reads of index 0x8 return 0xFF.
- R8: Index 0xC stores data bits 4:0, resets to 0, and reads back as {3'b000, stored bits}. `ee_en` is bit 2. `ee_scl` is bit 0 and `ee_sda` is bit 1 while bit 2 is set; both are 0 while bit 2 is clear.
- R9: `data_io` is driven only while `rd_n` is low and is high impedance otherwise.
- R10: At any pointer value with no register behind it (0x6, 0x9 to 0xB, 0xD to 0xF), reads return 0xFF and writes change nothing.
- R11: If a button press edge and a write to that button's clear location take effect on the same clock edge, the latch is set.
- R12: Writes to index 0x0 have no effect on the button latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_a0 | input | 1 | Address line: 0 selects the pointer, 1 selects the indirect window |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; commits on its rising edge |
| data_io | inout | 8 | Bidirectional data bus |
| btn_raw | input | 5 | Asynchronous button inputs, high while pressed |
| led_n | output | 4 | LED drives, active low |
| seg_n | output | 8 | Seven-segment drives, active low (A..G, DP) |
| ee_en | output | 1 | EEPROM pin drive enable |
| ee_scl | output | 1 | EEPROM clock pin drive value |
| ee_sda | output | 1 | EEPROM data pin drive value |

## Verification
The assertions check several rules on every cycle. The strobes are never both low. The bus carries a known value whenever it is read. A detected press always leaves its latch set, and no latch is released without a committed write. The LED, display and EEPROM enable outputs change only after a committed write. The bench scenarios cover what the assertions cannot: the exact register indices and bit positions, the rule that holding a button does not set its latch again, ignored writes to unimplemented and read-only indices, pointer aliasing above four bits, the release of the bus when the read strobe is high, and the case where a press and its clear land on the same edge.

// File: rtl/bcb_pkg.sv
package bcb_pkg;

    localparam int BUS_W  = 8;
    localparam int PTR_W  = 4;
    localparam int BTN_N  = 5;
    localparam int LED_N  = 4;
    localparam int EE_W   = 5;
    localparam int SYNC_W = BUS_W + 2;

    localparam logic [PTR_W-1:0] IX_BTN_STAT = 4'h0;
    localparam logic [PTR_W-1:0] IX_CLR_BASE = 4'h1;
    localparam logic [PTR_W-1:0] IX_LED      = 4'h7;
    localparam logic [PTR_W-1:0] IX_SEG      = 4'h8;
    localparam logic [PTR_W-1:0] IX_EE       = 4'hC;

    localparam int EE_SCL_BIT = 0;
    localparam int EE_SDA_BIT = 1;
    localparam int EE_EN_BIT  = 2;

    localparam logic [BUS_W-1:0] RD_VOID = '1;

    typedef struct packed {
        logic             valid;
        logic             a0;
        logic [BUS_W-1:0] data;
    } wr_cmd_t;

    typedef struct packed {
        logic             wr_n;
        logic             a0;
        logic [BUS_W-1:0] data;
    } bus_smp_t;

    function automatic logic is_clear_ix(input logic [PTR_W-1:0] p, input int btn);
        return p == (IX_CLR_BASE + PTR_W'(btn));
    endfunction

endpackage

// File: rtl/bcb_sync.sv
module bcb_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/bcb_bus_if.sv
module bcb_bus_if
    import bcb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             a0,
    input  logic             wr_n,
    input  logic [BUS_W-1:0] bus_in,
    output wr_cmd_t          cmd
);

    localparam bus_smp_t SMP_RST = '{wr_n: 1'b1, a0: 1'b0, data: '0};

    bus_smp_t raw;
    bus_smp_t smp;
    logic     wr_n_prev;
    logic     hold_a0;
    logic [BUS_W-1:0] hold_data;

    assign raw = '{wr_n: wr_n, a0: a0, data: bus_in};

    bcb_sync #(.W(SYNC_W), .RST_VAL(SMP_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (smp)
    );

    // Address and data are held from the last cycle the strobe was low,
    // so the host may change them as soon as the strobe has risen.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_prev <= 1'b1;
            hold_a0   <= 1'b0;
            hold_data <= '0;
        end else begin
            wr_n_prev <= smp.wr_n;
            if (!smp.wr_n) begin
                hold_a0   <= smp.a0;
                hold_data <= smp.data;
            end
        end
    end

    always_comb begin
        cmd.valid = smp.wr_n && !wr_n_prev;
        cmd.a0    = hold_a0;
        cmd.data  = hold_data;
    end

endmodule

// File: rtl/bcb_btn_bank.sv
module bcb_btn_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] btn_raw,
    input  logic [N-1:0] clr,
    output logic [N-1:0] press,
    output logic [N-1:0] stat_n
);

    logic [N-1:0] btn_s;
    logic [N-1:0] btn_prev;

    bcb_sync #(.W(N), .RST_VAL('0)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (btn_raw),
        .q   (btn_s)
    );

    always_ff @(posedge clk) begin
        if (rst) btn_prev <= '0;
        else     btn_prev <= btn_s;
    end

    assign press = btn_s & ~btn_prev;

    for (genvar i = 0; i < N; i++) begin : g_latch
        always_ff @(posedge clk) begin
            if (rst)           stat_n[i] <= 1'b1;
            else if (press[i]) stat_n[i] <= 1'b0;
            else if (clr[i])   stat_n[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/board_ctl_bank.sv
module board_ctl_bank
    import bcb_pkg::*;
#(
    parameter int NBTN = BTN_N,
    parameter int NLED = LED_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_a0,
    input  logic             rd_n,
    input  logic             wr_n,
    inout  wire  [BUS_W-1:0] data_io,
    input  logic [NBTN-1:0]  btn_raw,
    output logic [NLED-1:0]  led_n,
    output logic [BUS_W-1:0] seg_n,
    output logic             ee_en,
    output logic             ee_scl,
    output logic             ee_sda
);

    localparam int STAT_PAD = BUS_W - NBTN;
    localparam int EE_PAD   = BUS_W - EE_W;

    wr_cmd_t          cmd;
    logic             ptr_wr;
    logic             win_wr;
    logic [PTR_W-1:0] ptr_q;
    logic [NBTN-1:0]  clr_vec;
    logic [NBTN-1:0]  press;
    logic [NBTN-1:0]  stat_n;
    logic [NLED-1:0]  led_q;
    logic [BUS_W-1:0] seg_q;
    logic [EE_W-1:0]  ee_q;
    logic [BUS_W-1:0] rd_val;
    logic             wr_stb;

    bcb_bus_if u_bus (
        .clk    (clk),
        .rst    (rst),
        .a0     (bus_a0),
        .wr_n   (wr_n),
        .bus_in (data_io),
        .cmd    (cmd)
    );

    assign wr_stb = cmd.valid;
    assign ptr_wr = cmd.valid && !cmd.a0;
    assign win_wr = cmd.valid &&  cmd.a0;

    for (genvar i = 0; i < NBTN; i++) begin : g_clr
        assign clr_vec[i] = win_wr && is_clear_ix(ptr_q, i);
    end

    bcb_btn_bank #(.N(NBTN)) u_btn (
        .clk     (clk),
        .rst     (rst),
        .btn_raw (btn_raw),
        .clr     (clr_vec),
        .press   (press),
        .stat_n  (stat_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= IX_BTN_STAT;
            led_q <= '1;
            seg_q <= '1;
            ee_q  <= '0;
        end else begin
            if (ptr_wr) ptr_q <= cmd.data[PTR_W-1:0];
            if (win_wr) begin
                unique case (ptr_q)
                    IX_LED:  led_q <= cmd.data[NLED-1:0];
                    IX_SEG:  seg_q <= cmd.data;
                    IX_EE:   ee_q  <= cmd.data[EE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_val = RD_VOID;
        if (bus_a0) begin
            unique case (ptr_q)
                IX_BTN_STAT: rd_val = {{STAT_PAD{1'b1}}, stat_n};
                IX_EE:       rd_val = {{EE_PAD{1'b0}}, ee_q};
                default:     rd_val = RD_VOID;
            endcase
        end
    end

    assign data_io = (!rd_n) ? rd_val : 'z;

    assign led_n  = led_q;
    assign seg_n  = seg_q;
    assign ee_en  = ee_q[EE_EN_BIT];
    assign ee_scl = ee_q[EE_EN_BIT] & ee_q[EE_SCL_BIT];
    assign ee_sda = ee_q[EE_EN_BIT] & ee_q[EE_SDA_BIT];

endmodule

// File: rtl/bcb_chk.sv
module bcb_chk #(
    parameter int NBTN = 5,
    parameter int NLED = 4,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            rd_n,
    input logic            wr_n,
    input logic [DW-1:0]   data_io,
    input logic            wr_stb,
    input logic [NBTN-1:0] press,
    input logic [NBTN-1:0] stat_n,
    input logic [NLED-1:0] led_n,
    input logic [DW-1:0]   seg_n,
    input logic            ee_en
);

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    a_r9_bus_known: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !$isunknown(data_io));

    a_r4_press_latches: assert property (@(posedge clk) disable iff (rst)
        (|press) |=> ((stat_n & $past(press)) == '0));

    a_r5_clear_by_write: assert property (@(posedge clk) disable iff (rst)
        (|(stat_n & ~$past(stat_n))) |-> $past(wr_stb));

    a_r6_led_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_stb) |-> $stable(led_n));

    a_r7_seg_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_stb) |-> $stable(seg_n));

    a_r8_ee_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_stb) |-> $stable(ee_en));

endmodule

bind board_ctl_bank bcb_chk #(.NBTN(NBTN), .NLED(NLED), .DW(bcb_pkg::BUS_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .data_io (data_io),
    .wr_stb  (wr_stb),
    .press   (press),
    .stat_n  (stat_n),
    .led_n   (led_n),
    .seg_n   (seg_n),
    .ee_en   (ee_en)
);

// File: tb/sim_board_ctl_bank.sv
`timescale 1ns/1ps
module sim_board_ctl_bank;

    localparam int K_BUS = 0;
    localparam int K_LED = 1;
    localparam int K_SEG = 2;
    localparam int K_EE  = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a0 = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] drv = 8'h00;
    logic       drv_en = 1'b0;
    logic [4:0] btn = 5'b0;
    wire  [7:0] bus;
    logic [3:0] led_n;
    logic [7:0] seg_n;
    logic       ee_en, ee_scl, ee_sda;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    int         kind_q[$];
    string      req_q[$];
    event       samp;

    assign bus = drv_en ? drv : 8'hzz;

    always #10 clk = ~clk;

    board_ctl_bank u0 (
        .clk     (clk),
        .rst     (rst),
        .bus_a0  (a0),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .data_io (bus),
        .btn_raw (btn),
        .led_n   (led_n),
        .seg_n   (seg_n),
        .ee_en   (ee_en),
        .ee_scl  (ee_scl),
        .ee_sda  (ee_sda)
    );

    // Monitor: pops the expected item and compares it with the observed value.
    initial begin
        forever begin
            @(samp);
            if (exp_q.size() != 0) begin
                logic [7:0] e;
                logic [7:0] got;
                int         k;
                string      r;
                e = exp_q.pop_front();
                k = kind_q.pop_front();
                r = req_q.pop_front();
                case (k)
                    K_BUS:   got = bus;
                    K_LED:   got = {4'h0, led_n};
                    K_SEG:   got = seg_n;
                    default: got = {5'b0, ee_en, ee_sda, ee_scl};
                endcase
                total++;
                if (got !== e) begin
                    bad++;
                    $display("FAIL %s: got %02h expected %02h", r, got, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic addr, input logic [7:0] d);
        @(negedge clk);
        a0 = addr; drv = d; drv_en = 1'b1;
        tick(1);
        wr_n = 1'b0;
        tick(3);
        wr_n = 1'b1;
        tick(2);
        drv_en = 1'b0;
        tick(4);
    endtask

    task automatic put(input logic [3:0] ix, input logic [7:0] d);
        bus_write(1'b0, {4'h0, ix});
        bus_write(1'b1, d);
    endtask

    task automatic expect_read(input logic addr, input logic [7:0] e, input string r);
        @(negedge clk);
        a0 = addr; rd_n = 1'b0;
        #5;
        exp_q.push_back(e); kind_q.push_back(K_BUS); req_q.push_back(r);
        -> samp;
        #2;
        @(negedge clk);
        rd_n = 1'b1;
    endtask

    task automatic expect_out(input int k, input logic [7:0] e, input string r);
        @(negedge clk);
        #1;
        exp_q.push_back(e); kind_q.push_back(k); req_q.push_back(r);
        -> samp;
        #2;
    endtask

    task automatic get(input logic [3:0] ix, input logic [7:0] e, input string r);
        bus_write(1'b0, {4'h0, ix});
        expect_read(1'b1, e, r);
    endtask

    task automatic tap(input int b);
        @(negedge clk);
        btn[b] = 1'b1;
        tick(4);
        btn[b] = 1'b0;
        tick(4);
    endtask

    // Watchdog
    initial begin
        #(20 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);

        // Reset state
        expect_out(K_LED, 8'h0F, "R6 reset");
        expect_out(K_SEG, 8'hFF, "R7 reset");
        expect_out(K_EE,  8'h00, "R8 reset");
        expect_read(1'b1, 8'hFF, "R4 reset status");
        expect_read(1'b0, 8'hFF, "R1 pointer not readable");

        // R9: bus released while read strobe high: bench value shows through
        @(negedge clk);
        drv = 8'hA5; drv_en = 1'b1;
        #2;
        exp_q.push_back(8'hA5); kind_q.push_back(K_BUS); req_q.push_back("R9 bus released");
        -> samp;
        #2;
        drv_en = 1'b0;

        // R4: press latching
        tap(0);
        get(4'h0, 8'hFE, "R4 up latched");
        @(negedge clk); btn[4] = 1'b1;
        tick(6);
        expect_read(1'b1, 8'hEE, "R4 enter latched");

        // R5 + R4: clear enter while still held: no relatch
        put(4'h5, 8'h33);
        get(4'h0, 8'hFE, "R4 held button not relatched after R5 clear");
        @(negedge clk); btn[4] = 1'b0;
        put(4'h1, 8'h00);
        get(4'h0, 8'hFF, "R5 clear up");

        tap(1);
        tap(3);
        get(4'h0, 8'hF5, "R4 left and down latched");
        put(4'h2, 8'hC3);
        get(4'h0, 8'hF7, "R5 clear left only");

        // R12: write to status ignored
        put(4'h0, 8'h00);
        expect_read(1'b1, 8'hF7, "R12 status write ignored");

        // R6, R7
        put(4'h7, 8'h5A);
        expect_out(K_LED, 8'h0A, "R6 led write");
        expect_read(1'b1, 8'hFF, "R6 led read void");
        put(4'h8, 8'h3C);
        expect_out(K_SEG, 8'h3C, "R7 seg write");
        expect_read(1'b1, 8'hFF, "R7 seg read void");

        // R3: no commit while strobe still low
        bus_write(1'b0, 8'h07);
        @(negedge clk);
        a0 = 1'b1; drv = 8'h03; drv_en = 1'b1;
        tick(1);
        wr_n = 1'b0;
        tick(6);
        expect_out(K_LED, 8'h0A, "R3 no commit while strobe low");
        @(negedge clk);
        wr_n = 1'b1;
        tick(4);
        drv_en = 1'b0;
        expect_out(K_LED, 8'h03, "R3 commit after strobe rise");

        // R8
        put(4'hC, 8'h03);
        expect_out(K_EE, 8'h00, "R8 gated off");
        expect_read(1'b1, 8'h03, "R8 readback");
        put(4'hC, 8'h1F);
        expect_out(K_EE, 8'h07, "R8 enabled");
        expect_read(1'b1, 8'h1F, "R8 readback full");
        put(4'hC, 8'hE5);
        expect_out(K_EE, 8'h05, "R8 scl only");
        expect_read(1'b1, 8'h05, "R8 upper bits dropped");

        // R10: unimplemented indices
        put(4'h6, 8'h00);
        expect_read(1'b1, 8'hFF, "R10 read 0x6");
        put(4'h9, 8'h00);
        put(4'hD, 8'h00);
        put(4'hF, 8'h00);
        expect_read(1'b1, 8'hFF, "R10 read 0xF");
        expect_out(K_LED, 8'h03, "R10 led untouched");
        expect_out(K_SEG, 8'h3C, "R10 seg untouched");
        get(4'hC, 8'h05, "R10 ee untouched");

        // R1/R2: pointer keeps low four bits (0x17 selects 0x7)
        bus_write(1'b0, 8'h17);
        bus_write(1'b1, 8'h0F);
        expect_out(K_LED, 8'h0F, "R1 pointer low bits R2 window");

        // R11: press and clear on the same edge
        bus_write(1'b0, 8'h01);
        @(negedge clk);
        a0 = 1'b1; drv = 8'h00; drv_en = 1'b1;
        tick(1);
        wr_n = 1'b0;
        tick(3);
        wr_n = 1'b1; btn[0] = 1'b1;
        tick(2);
        drv_en = 1'b0;
        tick(4);
        btn[0] = 1'b0;
        get(4'h0, 8'hF6, "R11 press wins over clear");

        tick(4);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule